// File: doc/BRIEF.md
# Four-Stage Keyed Watchdog Timer

This block is a watchdog timer with four timeout stages that run one after another. A programmable prescaler divides the clock into ticks. Each stage waits a programmed number of ticks. When a stage times out, it performs its own action: nothing, a level interrupt, a CPU reset pulse or a system reset pulse. The watchdog then moves on to the next stage whose action is not "nothing". After the last such stage it stops until software feeds it or loads a new configuration.

Software reaches the block through a simple write port. Every register except the key register ignores writes unless the last value written to the key register was the unlock key. Configuration writes first land in shadow registers. They reach the timing logic only when a configuration word is written with its update bit set, and that update also restarts the sequence. A write to the feed address restarts the sequence from its first active stage without changing any setting.

Top module: `stage_watchdog`

## Requirements
- R1: After reset the watchdog is locked and not counting, and `irq_o`, `cpu_rst_o` and `sys_rst_o` are low.
- R2: A write to address 0 sets the block unlocked if the data is 0x50D83AA1 and locks it for any other value. While locked, writes to addresses 1 to 7 have no effect. The address map is: 1 config, 2 prescale, 3 feed, 4+i hold of stage i.
- R3: Config word layout: bit 0 enable, bits [2i+2:2i+1] action of stage i, bits [11:9] CPU reset length, bits [14:12] system reset length, bit 15 update. Shadow values for config, prescale and holds take effect only on a config write with bit 15 set. That write also restarts the sequence from its first active stage with all counters cleared.
- R4: The prescaler ticks once every P clocks, where P is the prescale value in bits [15:0] (P=0 counts as 1). A stage with hold value H expires P*max(H,1) clocks after the stage starts. An expiry seen at the ports one clock later is counted P*H clocks after the restarting write.
- R5: Writing the prescale address with bit 16 set clears the prescaler's running count at that write.
- R6: Any write to the feed address (3) restarts the sequence from its first active stage, with the prescaler and stage counters cleared.
- R7: Action codes are 0 none, 1 interrupt, 2 CPU reset, 3 system reset. Stages run in order 0 to 3, and stages with action 0 are skipped. After the last active stage expires, nothing further happens until a feed or an update.
- R8: The interrupt action sets `irq_o`, which stays high until `irq_clr` is asserted. Clearing takes effect one clock later, and a new expiry wins over a clear in the same cycle.
- R9: The CPU and system reset actions drive `cpu_rst_o` / `sys_rst_o` high for (L+1)*8 clocks, where L is the matching 3-bit length field. The pulse starts in the clock after the expiry.
- R10: With the enable bit at 0 in the active configuration, no stage counts and no action fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| irq_clr | input | 1 | Clears the interrupt level |
| irq_o | output | 1 | Level interrupt request |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions check properties that hold on every cycle. Locked writes must leave the shadow configuration unchanged. The interrupt level must hold until cleared and must fall after a clear. Prescaler ticks must be spaced as the divider sets. The stage count must stay below its hold value. A stopped sequence must stay stopped until restarted. Only stages with an active action may expire, and a reset pulse must last more than one clock. The exact timeout arithmetic over prescale and hold values, the order and skipping of chained stages, the feed and update restart points, the divider-count clear and the pulse widths for every length setting can only be shown by the bench's timed scenarios.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned STAGES = 4;
  localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;
  localparam int unsigned A_KEY  = 0;
  localparam int unsigned A_CFG  = 1;
  localparam int unsigned A_PRE  = 2;
  localparam int unsigned A_FEED = 3;
  localparam int unsigned A_HOLD = 4;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim  = (div == '0) ? '0 : div - 1'b1;
    tick = run && !clr && (cnt_q >= lim);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || lim == '0)); // R4
endmodule

// File: rtl/wdt_stage_seq.sv
module wdt_stage_seq
  import wdog_pkg::*;
#(
  parameter int unsigned HOLD_W = 32,
  localparam int unsigned SW = $clog2(STAGES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          restart,
  input  logic                          tick,
  input  logic [STAGES-1:0][1:0]        acts,
  input  logic [STAGES-1:0][1:0]        start_acts,
  input  logic [STAGES-1:0][HOLD_W-1:0] holds,
  output logic                          run,
  output logic                          expire,
  output logic [1:0]                    exp_act
);
  logic [SW-1:0]     stage_q, stage_d;
  logic              done_q, done_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d, hold_eff;
  logic [SW:0]       nxt, first;

  function automatic logic [SW:0] pick(input int from, input logic [STAGES-1:0][1:0] a);
    logic [SW:0] r;
    r = '0;
    for (int i = STAGES - 1; i >= 0; i--) begin
      if (i >= from && a[i] != ACT_NONE) r = {1'b1, SW'(i)};
    end
    return r;
  endfunction

  always_comb begin
    run      = enable && !done_q;
    hold_eff = (holds[stage_q] == '0) ? HOLD_W'(1) : holds[stage_q];
    expire   = run && tick && (cnt_q >= hold_eff - 1'b1);
    exp_act  = acts[stage_q];
    nxt      = pick(int'(stage_q) + 1, acts);
    first    = pick(0, start_acts);
    stage_d  = stage_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    if (restart) begin
      cnt_d   = '0;
      stage_d = first[SW-1:0];
      done_d  = !first[SW];
    end else if (expire) begin
      cnt_d = '0;
      if (nxt[SW]) stage_d = nxt[SW-1:0];
      else         done_d  = 1'b1;
    end else if (run && tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      done_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < hold_eff); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart) |=> done_q); // R7
  AST_EXPIRE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> exp_act != ACT_NONE); // R7
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN_W = 3,
  localparam int unsigned CW = LEN_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             pulse_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)              cnt_d = (CW'(len) + 1'b1) << 3;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |=> pulse_o); // R9
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned HOLD_W = 32,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned LEN_W  = 3,
  localparam int unsigned ADDR_W = 3,
  localparam int unsigned DATA_W = 32,
  localparam int unsigned EN_B   = 0,
  localparam int unsigned ACT_B  = 1,
  localparam int unsigned CPUL_B = ACT_B + 2 * STAGES,
  localparam int unsigned SYSL_B = CPUL_B + LEN_W,
  localparam int unsigned UPD_B  = SYSL_B + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic                          key_q, key_d;
  logic                          sh_en_q, sh_en_d, ac_en_q, ac_en_d;
  logic [STAGES-1:0][1:0]        sh_act_q, sh_act_d, ac_act_q, ac_act_d;
  logic [LEN_W-1:0]              sh_cl_q, sh_cl_d, ac_cl_q, ac_cl_d;
  logic [LEN_W-1:0]              sh_sl_q, sh_sl_d, ac_sl_q, ac_sl_d;
  logic [PRE_W-1:0]              sh_pre_q, sh_pre_d, ac_pre_q, ac_pre_d;
  logic [STAGES-1:0][HOLD_W-1:0] sh_hold_q, sh_hold_d, ac_hold_q, ac_hold_d;
  logic wr_ok, cfg_wr, update, feed, pre_wr, div_clr, restart;
  logic run, tick, expire, irq_set, irq_q, irq_d;
  logic [1:0] exp_act;

  always_comb begin
    wr_ok   = wr_en && key_q && (wr_addr != ADDR_W'(A_KEY));
    cfg_wr  = wr_ok && (wr_addr == ADDR_W'(A_CFG));
    update  = cfg_wr && wr_data[UPD_B];
    feed    = wr_ok && (wr_addr == ADDR_W'(A_FEED));
    pre_wr  = wr_ok && (wr_addr == ADDR_W'(A_PRE));
    div_clr = pre_wr && wr_data[PRE_W];
    restart = update || feed;

    key_d = key_q;
    if (wr_en && wr_addr == ADDR_W'(A_KEY)) key_d = (wr_data == DATA_W'(UNLOCK_KEY));

    sh_en_d  = sh_en_q;
    sh_act_d = sh_act_q;
    sh_cl_d  = sh_cl_q;
    sh_sl_d  = sh_sl_q;
    if (cfg_wr) begin
      sh_en_d = wr_data[EN_B];
      for (int i = 0; i < STAGES; i++) sh_act_d[i] = wr_data[ACT_B + 2 * i +: 2];
      sh_cl_d = wr_data[CPUL_B +: LEN_W];
      sh_sl_d = wr_data[SYSL_B +: LEN_W];
    end
    sh_pre_d = pre_wr ? wr_data[PRE_W-1:0] : sh_pre_q;
    sh_hold_d = sh_hold_q;
    for (int i = 0; i < STAGES; i++) begin
      if (wr_ok && wr_addr == ADDR_W'(A_HOLD + i)) sh_hold_d[i] = wr_data[HOLD_W-1:0];
    end

    ac_en_d   = update ? sh_en_d   : ac_en_q;
    ac_act_d  = update ? sh_act_d  : ac_act_q;
    ac_cl_d   = update ? sh_cl_d   : ac_cl_q;
    ac_sl_d   = update ? sh_sl_d   : ac_sl_q;
    ac_pre_d  = update ? sh_pre_d  : ac_pre_q;
    ac_hold_d = update ? sh_hold_d : ac_hold_q;

    irq_set = expire && (exp_act == ACT_IRQ);
    irq_d   = irq_set || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      key_q     <= 1'b0;
      sh_en_q   <= 1'b0;
      sh_act_q  <= '0;
      sh_cl_q   <= '0;
      sh_sl_q   <= '0;
      sh_pre_q  <= '0;
      sh_hold_q <= '0;
      ac_en_q   <= 1'b0;
      ac_act_q  <= '0;
      ac_cl_q   <= '0;
      ac_sl_q   <= '0;
      ac_pre_q  <= '0;
      ac_hold_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      key_q     <= key_d;
      sh_en_q   <= sh_en_d;
      sh_act_q  <= sh_act_d;
      sh_cl_q   <= sh_cl_d;
      sh_sl_q   <= sh_sl_d;
      sh_pre_q  <= sh_pre_d;
      sh_hold_q <= sh_hold_d;
      ac_en_q   <= ac_en_d;
      ac_act_q  <= ac_act_d;
      ac_cl_q   <= ac_cl_d;
      ac_sl_q   <= ac_sl_d;
      ac_pre_q  <= ac_pre_d;
      ac_hold_q <= ac_hold_d;
      irq_q     <= irq_d;
    end
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(srst_n), .run(run), .clr(restart || div_clr),
    .div(ac_pre_q), .tick(tick)
  );

  wdt_stage_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .enable(ac_en_q), .restart(restart),
    .tick(tick), .acts(ac_act_q), .start_acts(ac_act_d), .holds(ac_hold_q),
    .run(run), .expire(expire), .exp_act(exp_act)
  );

  wdt_pulse #(.LEN_W(LEN_W)) u_cpu (
    .clk(clk), .rst_n(srst_n), .fire(expire && exp_act == ACT_CPU),
    .len(ac_cl_q), .pulse_o(cpu_rst_o)
  );

  wdt_pulse #(.LEN_W(LEN_W)) u_sys (
    .clk(clk), .rst_n(srst_n), .fire(expire && exp_act == ACT_SYS),
    .len(ac_sl_q), .pulse_o(sys_rst_o)
  );

  assign irq_o = irq_q;

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!srst_n)
    (!key_q && wr_en && wr_addr == ADDR_W'(A_CFG)) |=> ($stable(sh_act_q) && $stable(sh_en_q))); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_q && !irq_clr) |=> irq_q); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_clr && !irq_set) |=> !irq_q); // R8
endmodule

// File: tb/stage_watchdog_bench.sv
module stage_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        irq_clr;
  logic        irq_o, cpu_rst_o, sys_rst_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  stage_watchdog u_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
  );

  localparam logic [31:0] KEY = 32'h50D8_3AA1;

  function automatic logic [31:0] cfgw(input bit en, input int a0, input int a1,
      input int a2, input int a3, input int cl, input int sl, input bit upd);
    return 32'(en) | (32'(a0) << 1) | (32'(a1) << 3) | (32'(a2) << 5) | (32'(a3) << 7)
         | (32'(cl) << 9) | (32'(sl) << 12) | (32'(upd) << 15);
  endfunction

  function automatic logic sig(input int which);
    return (which == 0) ? irq_o : (which == 1) ? cpu_rst_o : sys_rst_o;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_sig(input int which, output int n);
    n = 0;
    while (!sig(which) && n < 3000) begin
      @(negedge clk); n++;
    end
    if (!sig(which)) n = -1;
  endtask

  task automatic pulse_width(input int which, output int w);
    w = 0;
    while (sig(which) && w < 200) begin
      @(negedge clk); w++;
    end
  endtask

  task automatic quiet(input int which, input int cyc, output bit stayed_low);
    stayed_low = 1'b1;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (sig(which)) stayed_low = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, w, irq_at, cpu_at, sys_at, cpu_w, sys_w;
    bit lo;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; irq_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!irq_o && !cpu_rst_o && !sys_rst_o, "R1 outputs after reset",
          {irq_o, cpu_rst_o, sys_rst_o}, 0);

    // R2 locked writes are ignored
    wr(4, 3);
    wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
    quiet(0, 40, lo);
    check(lo, "R2 locked config ignored", int'(!lo), 0);
    wr(0, KEY);
    wr(2, 1); wr(4, 3);
    wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
    wait_sig(0, n);
    check(n == 3, "R2 unlocked config accepted", n, 3);
    clear_irq();
    wr(0, 0);
    wr(3, 0);
    quiet(0, 40, lo);
    check(lo, "R2 relocked feed ignored", int'(!lo), 0);
    wr(0, KEY);

    // R4 prescale x hold sweep
    for (int p = 1; p <= 3; p++) begin
      for (int hi = 0; hi < 4; hi++) begin
        int h, expv;
        h = (hi == 3) ? 5 : hi;
        expv = p * ((h == 0) ? 1 : h);
        wr(2, 32'(p)); wr(4, 32'(h));
        clear_irq();
        wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
        wait_sig(0, n);
        check(n == expv, $sformatf("R4 timeout p=%0d h=%0d", p, h), n, expv);
      end
    end

    // R8 level interrupt holds until cleared
    quiet(0, 20, lo);
    check(irq_o == 1'b1, "R8 irq holds", int'(irq_o), 1);
    clear_irq();
    check(irq_o == 1'b0, "R8 irq cleared", int'(irq_o), 0);

    // R7 R9 chained stages with a skipped stage
    wr(2, 2); wr(4, 3); wr(5, 100); wr(6, 4); wr(7, 2);
    wr(1, cfgw(1, 1, 0, 2, 3, 1, 0, 1));
    irq_at = -1; cpu_at = -1; sys_at = -1; cpu_w = 0; sys_w = 0;
    for (int c = 0; c < 120; c++) begin
      if (irq_o && irq_at < 0) irq_at = c;
      if (cpu_rst_o && cpu_at < 0) cpu_at = c;
      if (sys_rst_o && sys_at < 0) sys_at = c;
      if (cpu_rst_o) cpu_w++;
      if (sys_rst_o) sys_w++;
      @(negedge clk);
    end
    check(irq_at == 6, "R7 stage0 irq time", irq_at, 6);
    check(cpu_at == 14, "R7 stage2 after skipped stage1", cpu_at, 14);
    check(sys_at == 18, "R7 stage3 time", sys_at, 18);
    check(cpu_w == 16, "R9 cpu pulse len=1 single", cpu_w, 16);
    check(sys_w == 8, "R9 sys pulse len=0 single", sys_w, 8);
    clear_irq();

    // R7 only last stage active, then stop; R6 feed restarts
    wr(2, 1); wr(7, 4);
    wr(1, cfgw(1, 0, 0, 0, 1, 0, 0, 1));
    wait_sig(0, n);
    check(n == 4, "R7 skip to stage3", n, 4);
    clear_irq();
    quiet(0, 50, lo);
    check(lo, "R7 stopped after last stage", int'(!lo), 0);
    wr(3, 0);
    wait_sig(0, n);
    check(n == 4, "R6 feed restarts after stop", n, 4);
    clear_irq();

    // R6 feed in the middle of a stage
    wr(4, 10);
    wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
    repeat (5) @(negedge clk);
    wr(3, 32'hFFFF_FFFF);
    wait_sig(0, n);
    check(n == 10, "R6 feed restarts count", n, 10);
    clear_irq();

    // R3 shadow hold needs update
    wr(4, 7);
    wr(3, 0);
    wait_sig(0, n);
    check(n == 10, "R3 hold not applied before update", n, 10);
    clear_irq();
    wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
    wait_sig(0, n);
    check(n == 7, "R3 hold applied on update", n, 7);
    clear_irq();

    // R5 divider-count clear
    wr(2, 4); wr(4, 1);
    wr(1, cfgw(1, 1, 0, 0, 0, 0, 0, 1));
    wr(2, 32'h0001_0004);
    wait_sig(0, n);
    check(n == 4, "R5 divider count cleared", n, 4);
    clear_irq();

    // R10 disabled watchdog does nothing
    wr(2, 1); wr(4, 2);
    wr(1, cfgw(0, 1, 2, 3, 1, 0, 0, 1));
    quiet(0, 40, lo);
    check(lo && !cpu_rst_o && !sys_rst_o, "R10 disabled", int'(!lo), 0);

    // R9 pulse length sweep for both reset outputs
    for (int l = 0; l < 8; l++) begin
      for (int which = 1; which <= 2; which++) begin
        wr(4, 1);
        wr(1, cfgw(1, which + 1, 0, 0, 0, l, l, 1));
        wait_sig(which, n);
        pulse_width(which, w);
        check(n == 1 && w == (l + 1) * 8,
              $sformatf("R9 pulse width out=%0d len=%0d", which, l), w, (l + 1) * 8);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule